// File: doc/BRIEF.md
# Receive Match Character Synchronizer

This block sits between a serial receive pin and a receive FIFO in a transparent (non-framed) data path. It takes one bit per receive clock enable, gathers bits into octets and hands each finished octet to the FIFO as a single-cycle write strobe. When matching is switched off, loading starts with the very first bit after the receiver is enabled, and octets are cut every eight bits from that point.

When matching is switched on, the block writes nothing until a programmable character shows up in the stream. The search either slides one bit at a time or only tests octet boundaries. Once the character is found, it becomes the first octet written, and every later octet is cut on the grid set by the match. A status flag and a 3-bit offset report when and where, relative to the octet grid, the character was recognized. A receiver reset clears the status and starts the search again.

The stream can be free-running or gated to a time slot. In slot-gated mode, only bits inside the slot count, the octet grid restarts at each slot start, and a configuration bit picks MSB-first or LSB-first assembly.

Top module: `rx_match_sync`

## Requirements
- R1: After reset, and whenever `rx_en` is low, `fifo_wr`, `overrun`, `match_pulse` and `match_stat` are 0 and no bit is taken.
- R2: With `match_en` = 0, the first accepted bit after enable sets `match_stat` with `match_offset` = 000. Each group of eight accepted bits from that bit onward is written as one octet, first-received bit in bit 0 (LSB first).
- R3: With `match_en` = 1, no octet is written before the match character has been recognized.
- R4: With `align_octet` = 0, the match is tested at every bit once at least eight bits have been accepted. `match_offset` equals the grid position (0..7) of the bit that completes the match.
- R5: With `align_octet` = 1, the match is tested only on a bit at grid position 7, so a match is always reported with offset 111 and copies of the character off the grid are ignored.
- R6: The matched character is the first octet written. Each following group of eight bits, counted from the bit after the match, is written as the next octet.
- R7: `match_stat` rises on the first recognition and `match_offset` then holds its value until a receiver reset or disable.
- R8: A one-cycle `rx_rst` clears `match_stat` and the octet grid; with `match_en` = 1 the search starts over.
- R9: With `tdm_mode` = 1, bits arriving while `tdm_slot` = 0 are ignored. The first bit of each slot is grid position 0, and `tdm_msb_first` = 1 makes the first bit of an octet land in bit 7. With `tdm_mode` = 0, assembly is always LSB first.
- R10: If `fifo_full` is high when an octet is due, `fifo_wr` stays low, that octet is dropped and `overrun` pulses for one cycle.
- R11: `match_pulse` is high for one cycle, in the same cycle that the match character is offered to the FIFO (`fifo_wr` or `overrun`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; low holds the block cleared |
| rx_rst | input | 1 | Receiver reset pulse; clears status and restarts the search |
| bit_valid | input | 1 | Receive clock enable, one bit per high cycle |
| bit_in | input | 1 | Serial receive data |
| tdm_mode | input | 1 | 1 selects slot-gated operation |
| tdm_slot | input | 1 | Slot active, qualifies bits in slot-gated mode |
| tdm_msb_first | input | 1 | MSB-first assembly in slot-gated mode |
| match_en | input | 1 | 1 holds off loading until the match character is found |
| align_octet | input | 1 | 1 limits the search to octet boundaries |
| match_char | input | DATA_W | Match character |
| fifo_full | input | 1 | Receive FIFO cannot accept a write |
| fifo_wr | output | 1 | One-cycle write strobe |
| fifo_data | output | DATA_W | Octet offered to the FIFO |
| match_stat | output | 1 | Match (or first-bit) status |
| match_offset | output | $clog2(DATA_W) | Grid position of the match |
| match_pulse | output | 1 | One-cycle pulse when the match character is offered |
| overrun | output | 1 | One-cycle pulse when an octet is dropped |

## Verification
The match being recognized and the FIFO refusing a write can happen in the same cycle. The match character itself then arrives on a bit with `fifo_full` high. The bench provokes this by holding `fifo_full` high while the character is shifted in on the grid. In that cycle it expects `match_pulse` and `overrun` high, `fifo_wr` low and `match_stat` set. It then lowers `fifo_full` and expects the next octet, counted from the match, to be written normally. This shows that the dropped octet still anchored the grid.

// File: rtl/rms_pkg.sv
`timescale 1ns/1ps
package rms_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOAD = 1'b1
  } rms_state_e;
endpackage

// File: rtl/rms_bit_gate.sv
`timescale 1ns/1ps
module rms_bit_gate #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_en,
  input  logic             rx_rst,
  input  logic             bit_valid,
  input  logic             tdm_mode,
  input  logic             tdm_slot,
  output logic             bit_ok,
  output logic             clr,
  output logic [CNT_W-1:0] cur_pos
);
  logic [CNT_W-1:0] pos_q;
  logic             slot_prev_q;
  logic             slot_start;

  assign clr        = ~rx_en | rx_rst;
  assign bit_ok     = rx_en & ~rx_rst & bit_valid & (~tdm_mode | tdm_slot);
  assign slot_start = tdm_mode & tdm_slot & ~slot_prev_q;
  assign cur_pos    = slot_start ? '0 : pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q       <= '0;
      slot_prev_q <= 1'b0;
    end else begin
      if (clr) begin
        pos_q <= '0;
      end else if (bit_ok) begin
        pos_q <= cur_pos + {{(CNT_W-1){1'b0}}, 1'b1};
      end
      if (rx_rst) begin
        slot_prev_q <= 1'b0;
      end else if (bit_valid) begin
        slot_prev_q <= tdm_slot;
      end
    end
  end

  AST_GRID_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> pos_q == '0); // R8
endmodule

// File: rtl/rms_shifter.sv
`timescale 1ns/1ps
module rms_shifter #(
  parameter int DATA_W = 8,
  parameter int FILL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              bit_ok,
  input  logic              bit_in,
  input  logic              msb_first,
  output logic [DATA_W-1:0] win_next,
  output logic              win_full
);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q;
  logic [FILL_W-1:0] fill_q;
  logic [DATA_W-1:0] in_lsb;
  logic [DATA_W-1:0] in_msb;

  assign in_lsb   = {bit_in, sh_q[DATA_W-1:1]};
  assign in_msb   = {sh_q[DATA_W-2:0], bit_in};
  assign win_next = msb_first ? in_msb : in_lsb;
  assign win_full = (fill_q == FILL_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      fill_q <= '0;
    end else if (clr) begin
      sh_q   <= '0;
      fill_q <= '0;
    end else if (bit_ok) begin
      sh_q <= win_next;
      if (fill_q != FILL_MAX) begin
        fill_q <= fill_q + {{(FILL_W-1){1'b0}}, 1'b1};
      end
    end
  end

  AST_FILL_SATURATES: assert property (@(posedge clk) disable iff (rst)
    ($past(win_full) && !$past(clr)) |-> win_full); // R4
endmodule

// File: rtl/rms_detector.sv
`timescale 1ns/1ps
module rms_detector #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic [DATA_W-1:0] win_next,
  input  logic [DATA_W-1:0] match_char,
  input  logic              win_full,
  input  logic              align_octet,
  input  logic [CNT_W-1:0]  cur_pos,
  output logic              hit
);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] eq;

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_cmp
    assign eq[gi] = ~(win_next[gi] ^ match_char[gi]);
  end

  assign hit = (&eq) & win_full & (~align_octet | (cur_pos == LAST_POS));
endmodule

// File: rtl/rx_match_sync.sv
`timescale 1ns/1ps
module rx_match_sync #(
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rx_en,
  input  logic                      rx_rst,
  input  logic                      bit_valid,
  input  logic                      bit_in,
  input  logic                      tdm_mode,
  input  logic                      tdm_slot,
  input  logic                      tdm_msb_first,
  input  logic                      match_en,
  input  logic                      align_octet,
  input  logic [DATA_W-1:0]         match_char,
  input  logic                      fifo_full,
  output logic                      fifo_wr,
  output logic [DATA_W-1:0]         fifo_data,
  output logic                      match_stat,
  output logic [$clog2(DATA_W)-1:0] match_offset,
  output logic                      match_pulse,
  output logic                      overrun
);
  import rms_pkg::*;

  localparam int CNT_W = $clog2(DATA_W);
  localparam int FILL_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(DATA_W - 1);

  logic              bit_ok;
  logic              clr;
  logic [CNT_W-1:0]  cur_pos;
  logic [DATA_W-1:0] win_next;
  logic              win_full;
  logic              hit;
  logic              msb_first;
  logic              last_pos;
  logic              wr_req;
  rms_state_e        state_q;
  logic [CNT_W-1:0]  pcnt_q;

  assign msb_first = tdm_mode & tdm_msb_first;
  assign last_pos  = (cur_pos == LAST_POS);

  rms_bit_gate #(.CNT_W(CNT_W)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .rx_en     (rx_en),
    .rx_rst    (rx_rst),
    .bit_valid (bit_valid),
    .tdm_mode  (tdm_mode),
    .tdm_slot  (tdm_slot),
    .bit_ok    (bit_ok),
    .clr       (clr),
    .cur_pos   (cur_pos)
  );

  rms_shifter #(.DATA_W(DATA_W), .FILL_W(FILL_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .bit_ok    (bit_ok),
    .bit_in    (bit_in),
    .msb_first (msb_first),
    .win_next  (win_next),
    .win_full  (win_full)
  );

  rms_detector #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_det (
    .win_next    (win_next),
    .match_char  (match_char),
    .win_full    (win_full),
    .align_octet (align_octet),
    .cur_pos     (cur_pos),
    .hit         (hit)
  );

  always_comb begin
    wr_req = 1'b0;
    if (bit_ok) begin
      if (state_q == ST_HUNT) begin
        wr_req = match_en ? hit : last_pos;
      end else begin
        wr_req = match_en ? (pcnt_q == LAST_POS) : last_pos;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_HUNT;
      pcnt_q       <= '0;
      match_stat   <= 1'b0;
      match_offset <= '0;
      match_pulse  <= 1'b0;
      fifo_wr      <= 1'b0;
      fifo_data    <= '0;
      overrun      <= 1'b0;
    end else begin
      fifo_wr     <= 1'b0;
      overrun     <= 1'b0;
      match_pulse <= 1'b0;
      if (clr) begin
        state_q      <= ST_HUNT;
        pcnt_q       <= '0;
        match_stat   <= 1'b0;
        match_offset <= '0;
      end else if (bit_ok) begin
        if (state_q == ST_HUNT) begin
          if (!match_en) begin
            state_q      <= ST_LOAD;
            match_stat   <= 1'b1;
            match_offset <= '0;
          end else if (hit) begin
            state_q      <= ST_LOAD;
            match_stat   <= 1'b1;
            match_offset <= cur_pos;
            match_pulse  <= 1'b1;
            pcnt_q       <= '0;
          end
        end else begin
          pcnt_q <= (pcnt_q == LAST_POS) ? '0 : pcnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
        end
        if (wr_req) begin
          fifo_data <= win_next;
          if (fifo_full) begin
            overrun <= 1'b1;
          end else begin
            fifo_wr <= 1'b1;
          end
        end
      end
    end
  end

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !$past(rx_en) |-> (!fifo_wr && !match_stat && !overrun)); // R1
  AST_WR_NEEDS_STAT: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> match_stat); // R3
  AST_ALIGNED_OFS: assert property (@(posedge clk) disable iff (rst)
    (match_pulse && $past(align_octet)) |-> match_offset == LAST_POS); // R5
  AST_OFFSET_HELD: assert property (@(posedge clk) disable iff (rst)
    (match_stat && $past(match_stat)) |-> $stable(match_offset)); // R7
  AST_RRES_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rx_rst) |-> !match_stat); // R8
  AST_WR_XOR_OVR: assert property (@(posedge clk) disable iff (rst)
    !(fifo_wr && overrun)); // R10
  AST_PULSE_OFFERS: assert property (@(posedge clk) disable iff (rst)
    match_pulse |-> ((fifo_wr || overrun) && $past(match_en))); // R11
  AST_PULSE_ONCE: assert property (@(posedge clk) disable iff (rst)
    match_pulse |=> !match_pulse); // R11
endmodule

// File: tb/rx_match_sync_bench.sv
`timescale 1ns/1ps
module rx_match_sync_bench;
  logic       clk = 1'b0;
  logic       rst, rx_en, rx_rst, bit_valid, bit_in;
  logic       tdm_mode, tdm_slot, tdm_msb_first, match_en, align_octet;
  logic [7:0] match_char;
  logic       fifo_full;
  logic       fifo_wr, match_stat, match_pulse, overrun;
  logic [7:0] fifo_data;
  logic [2:0] match_offset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  rx_match_sync u_rx_match_sync (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rx_rst(rx_rst),
    .bit_valid(bit_valid), .bit_in(bit_in), .tdm_mode(tdm_mode),
    .tdm_slot(tdm_slot), .tdm_msb_first(tdm_msb_first),
    .match_en(match_en), .align_octet(align_octet), .match_char(match_char),
    .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
    .match_stat(match_stat), .match_offset(match_offset),
    .match_pulse(match_pulse), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: every write is popped against the scoreboard (R6)
  always begin
    @(posedge clk);
    #1;
    if (!rst && fifo_wr) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected write", fifo_data, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(fifo_data == e, "R6 written octet", fifo_data, e);
      end
    end
  end

  task automatic send_bit(input logic b, input logic s);
    @(negedge clk);
    bit_valid = 1'b1;
    bit_in    = b;
    tdm_slot  = s;
    @(posedge clk);
    #1;
  endtask

  task automatic send_byte(input logic [7:0] v, input logic msb, input logic s);
    for (int i = 0; i < 8; i++) begin
      send_bit(msb ? v[7-i] : v[i], s);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic pulse_rrst();
    @(negedge clk);
    bit_valid = 1'b0;
    rx_rst    = 1'b1;
    @(negedge clk);
    rx_rst    = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; rx_en = 1'b0; rx_rst = 1'b0; bit_valid = 1'b0; bit_in = 1'b0;
    tdm_mode = 1'b0; tdm_slot = 1'b0; tdm_msb_first = 1'b0;
    match_en = 1'b0; align_octet = 1'b0; match_char = 8'h7E; fifo_full = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    chk(!fifo_wr && !overrun && !match_pulse && !match_stat, "R1 reset outputs",
        {fifo_wr, overrun, match_pulse, match_stat}, 0);
    // R1: bits ignored while disabled
    send_byte(8'hFF, 1'b0, 1'b0);
    send_byte(8'h00, 1'b0, 1'b0);
    chk(!match_stat, "R1 status while disabled", match_stat, 0);

    // R2: matching off, loading from first bit, LSB first
    idle();
    rx_en = 1'b1;
    exp_q.push_back(8'hA5);
    exp_q.push_back(8'h3C);
    send_bit(1'b1, 1'b0);
    chk(match_stat == 1'b1, "R2 status on first bit", match_stat, 1);
    chk(match_offset == 3'd0, "R2 offset 000", match_offset, 0);
    for (int i = 1; i < 8; i++) send_bit(logic'(8'hA5 >> i), 1'b0);
    send_byte(8'h3C, 1'b0, 1'b0);

    // R3 R4 R6: sliding search, match ends at grid position 2
    pulse_rrst();
    match_en = 1'b1;
    align_octet = 1'b0;
    send_bit(1'b0, 1'b0);
    send_bit(1'b0, 1'b0);
    send_bit(1'b1, 1'b0);
    for (int i = 0; i < 7; i++) send_bit(logic'(8'h7E >> i), 1'b0);
    chk(!match_stat, "R3 no status before match", match_stat, 0);
    exp_q.push_back(8'h7E);
    exp_q.push_back(8'h55);
    send_bit(1'b0, 1'b0);
    chk(match_pulse && fifo_wr, "R11 pulse with write", {match_pulse, fifo_wr}, 3);
    chk(match_offset == 3'd2, "R4 sliding offset", match_offset, 2);
    send_byte(8'h55, 1'b0, 1'b0);
    chk(match_offset == 3'd2 && match_stat, "R7 offset held", match_offset, 2);

    // R8 R5: receiver reset, octet-aligned search ignores off-grid copy
    pulse_rrst();
    chk(!match_stat, "R8 status cleared", match_stat, 0);
    align_octet = 1'b1;
    send_bit(1'b0, 1'b0);
    send_bit(1'b0, 1'b0);
    send_bit(1'b1, 1'b0);
    send_byte(8'h7E, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) send_bit(1'b0, 1'b0);
    chk(!match_stat, "R5 off-grid copy ignored", match_stat, 0);
    exp_q.push_back(8'h7E);
    exp_q.push_back(8'hC3);
    send_byte(8'h7E, 1'b0, 1'b0);
    chk(match_stat && match_offset == 3'd7, "R5 aligned offset 111", match_offset, 7);
    send_byte(8'hC3, 1'b0, 1'b0);

    // R10 R11: match character arrives while FIFO is full
    pulse_rrst();
    align_octet = 1'b0;
    fifo_full = 1'b1;
    send_byte(8'h7E, 1'b0, 1'b0);
    chk(match_pulse && overrun && !fifo_wr, "R10 R11 match with full FIFO",
        {match_pulse, overrun, fifo_wr}, 6);
    chk(match_stat && match_offset == 3'd7, "R7 status despite drop", match_offset, 7);
    idle();
    fifo_full = 1'b0;
    exp_q.push_back(8'h11);
    send_byte(8'h11, 1'b0, 1'b0);
    chk(!overrun, "R10 overrun is one pulse", overrun, 0);

    // R9: slot gating, slot start restarts the grid, bit order select
    pulse_rrst();
    match_en = 1'b0;
    tdm_mode = 1'b1;
    tdm_msb_first = 1'b1;
    for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0);
    chk(!match_stat, "R9 bits outside slot ignored", match_stat, 0);
    exp_q.push_back(8'hB4);
    send_byte(8'hB4, 1'b1, 1'b1);
    send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b1);
    send_bit(1'b0, 1'b0);
    send_bit(1'b1, 1'b0);
    exp_q.push_back(8'h2D);
    send_byte(8'h2D, 1'b1, 1'b1);
    tdm_msb_first = 1'b0;
    send_bit(1'b1, 1'b0);
    exp_q.push_back(8'h6A);
    send_byte(8'h6A, 1'b0, 1'b1);
    idle();
    repeat (3) @(posedge clk);
    #1;
    chk(exp_q.size() == 0, "R6 all expected octets written", exp_q.size(), 0);
    finish_run();
  end
endmodule